// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a small window of 32-bit words through which it reaches an 8-bit internal register space belonging to a protocol engine. Instead of mapping every engine register into the host address map, the host places an internal address, a data byte and a direction flag into a single command word. The bridge then performs that one access on the internal side, which advances only on a slow-rate tick. While the access is in flight the command word reports itself busy. Once the access is done, a read leaves the fetched byte in the top byte of the same word.

Beside the command word the window holds the engine control word and three interrupt words. The control word carries a soft reset and a clock mode for the engine. The interrupt words are a mask, a write-one-to-clear word and a status word. Transmit-done and receive-done event pulses from the engine set status bits. The interrupt output goes high whenever an enabled status bit is set. Host software polls the busy bit before each new command and abandons the attempt after a timeout of a few milliseconds.

The host side uses a single-cycle write strobe, a word index and combinational read data. The internal side presents an address, write data, one-cycle read and write strobes, and takes read data back on the same cycle as the strobe. The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset on the second clock edge after `rst_n` rises.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the control word (index 0) reads 0x00000001: soft reset asserted, clock mode off. The command (1), mask (2), clear (3) and status (4) words read 0 and `irq` is low. Reset takes effect asynchronously and is released on the second rising clock edge after `rst_n` goes high.
- R2: Control word bits [2:0] are writable and the upper bits read 0. `eng_srst` follows bit 0 and `clk_mode` follows bits [2:1], where 0 is off, 1 is gated, 2 is free-running and 3 is reserved. `eng_clk_on` is high only for modes 1 and 2.
- R3: A write to the command word while it is idle and soft reset is low latches the fields: bits [7:0] internal address, bits [15:8] write data, bit 16 direction (1 = write). Busy (bit 23) reads 1 from the next cycle, and the latched fields read back unchanged until the next accepted command.
- R4: The access is performed on the ACCESS_TICKS-th cycle with `slow_tick` high, counting from the cycle after the command write. In that cycle exactly one of `int_we` or `int_re` is high, with `int_addr` and `int_wdata` equal to the latched fields. Busy reads 0 from the following cycle.
- R5: For a read access, bits [31:24] show the `int_rdata` value sampled in the strobe cycle. A write access leaves bits [31:24] unchanged.
- R6: A command word write while busy is set has no effect on the latched fields, the access in progress or its result.
- R7: While soft reset is set, busy drops on the next cycle and an access in progress is abandoned with no strobe. Bits [31:24] read 0x00, and command writes are ignored.
- R8: Mask word bits 1 (transmit) and 2 (receive) are writable. All other bits read 0.
- R9: A pulse on `ev_tx` or `ev_rx` sets status bit 1 or 2 respectively, and the bit stays set until cleared. Writing 1 to the same bit of the clear word clears it, and writing 0 leaves it. A set and a clear in the same cycle leave the bit set. The clear word reads 0.
- R10: `irq` is high exactly when some status bit is set with its mask bit at 1. Status bits set regardless of the mask.
- R11: Writes to the status word or to indices 5 to 7 change nothing, and reads of indices 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 3 | Host word index (0 control, 1 command, 2 mask, 3 clear, 4 status) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word selected by host_addr, combinational |
| slow_tick | input | 1 | Internal domain advance enable |
| int_we | output | 1 | Internal write strobe |
| int_re | output | 1 | Internal read strobe |
| int_addr | output | 8 | Internal register address |
| int_wdata | output | 8 | Internal write data |
| int_rdata | input | 8 | Internal read data, valid during int_re |
| ev_tx | input | 1 | Transmit event pulse |
| ev_rx | input | 1 | Receive event pulse |
| irq | output | 1 | Interrupt request |
| eng_srst | output | 1 | Engine soft reset |
| clk_mode | output | 2 | Engine clock mode |
| eng_clk_on | output | 1 | Engine clock running (mode 1 or 2) |

## Verification
The bench drives a second command into the middle of a busy access. A bridge that accepted it would retarget the strobe or corrupt the returned byte. It raises soft reset partway through an access and then tries to issue commands while soft reset is held. A faulty design would still fire a strobe, keep busy high or report a stale byte. It runs accesses with a sparse tick and with a tick on every cycle, which catches an off-by-one in the tick count as a strobe one tick early or late. It also places an event pulse and a clear in the same cycle, and writes to the status word and unmapped indices. A wrong priority or a loose decode shows up as a dropped or altered status bit.

// File: rtl/ireg_bridge_pkg.sv
package ireg_bridge_pkg;

  localparam int HOST_AW = 3;
  localparam int IADDR_W = 8;
  localparam int IDATA_W = 8;
  localparam int NUM_IRQ = 2;
  localparam int IRQ_LSB = 1;

  localparam int CMD_WDATA_LSB = 8;
  localparam int CMD_WE_BIT    = 16;
  localparam int CMD_BUSY_BIT  = 23;
  localparam int CMD_RDATA_LSB = 24;

  typedef enum logic [HOST_AW-1:0] {
    WIN_CTRL   = 3'd0,
    WIN_CMD    = 3'd1,
    WIN_MASK   = 3'd2,
    WIN_CLEAR  = 3'd3,
    WIN_STATUS = 3'd4
  } win_sel_e;

  typedef enum logic [1:0] {
    CLK_OFF   = 2'd0,
    CLK_GATED = 2'd1,
    CLK_FREE  = 2'd2,
    CLK_RSVD  = 2'd3
  } clk_mode_e;

  typedef struct packed {
    logic               we;
    logic [IDATA_W-1:0] wdata;
    logic [IADDR_W-1:0] addr;
  } icmd_t;

  localparam logic [2:0] CTRL_RST_VAL = 3'b001;

endpackage

// File: rtl/ireg_ctrl_regs.sv
module ireg_ctrl_regs
  import ireg_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wdata,
  output logic       srst,
  output clk_mode_e  mode
);

  logic [2:0] ctrl_q;
  logic [2:0] ctrl_n;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en) ctrl_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST_VAL;
    else        ctrl_q <= ctrl_n;
  end

  assign srst = ctrl_q[0];
  assign mode = clk_mode_e'(ctrl_q[2:1]);

endmodule

// File: rtl/ireg_access_seq.sv
module ireg_access_seq
  import ireg_bridge_pkg::*;
#(
  parameter int ACCESS_TICKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               start_req,
  input  icmd_t              cmd_in,
  input  logic               slow_tick,
  input  logic [IDATA_W-1:0] int_rdata,
  output logic               busy,
  output icmd_t              cmd_q,
  output logic [IDATA_W-1:0] rd_q,
  output logic               int_we,
  output logic               int_re
);

  localparam int CNT_W = (ACCESS_TICKS > 1) ? $clog2(ACCESS_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_TICKS - 1);

  logic               busy_q, busy_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  icmd_t              cmd_n;
  logic [IDATA_W-1:0] rd_n;
  logic               accept;
  logic               fire;

  assign accept = start_req & ~busy_q & ~srst;
  assign fire   = busy_q & slow_tick & ~srst & (cnt_q == CNT_LAST);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    cmd_n  = cmd_q;
    rd_n   = rd_q;
    if (srst) begin
      busy_n = 1'b0;
      cnt_n  = '0;
      rd_n   = '0;
    end else if (accept) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      cmd_n  = cmd_in;
    end else if (busy_q && slow_tick) begin
      if (fire) begin
        busy_n = 1'b0;
        cnt_n  = '0;
        if (!cmd_q.we) rd_n = int_rdata;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      cmd_q  <= cmd_n;
      rd_q   <= rd_n;
    end
  end

  assign busy   = busy_q;
  assign int_we = fire & cmd_q.we;
  assign int_re = fire & ~cmd_q.we;

endmodule

// File: rtl/ireg_irq_unit.sv
module ireg_irq_unit
  import ireg_bridge_pkg::*;
#(
  parameter int NSRC = NUM_IRQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            mask_wr,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] wsrc,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] stat_q,
  output logic            irq
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic mask_n;
    logic stat_n;

    always_comb begin
      mask_n = mask_q[g];
      if (mask_wr) mask_n = wsrc[g];
    end

    always_comb begin
      stat_n = stat_q[g];
      if (clr_wr && wsrc[g]) stat_n = 1'b0;
      if (ev[g])             stat_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= 1'b0;
        stat_q[g] <= 1'b0;
      end else begin
        mask_q[g] <= mask_n;
        stat_q[g] <= stat_n;
      end
    end
  end

  assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_bridge_pkg::*;
#(
  parameter int ACCESS_TICKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  input  logic                slow_tick,
  output logic                int_we,
  output logic                int_re,
  output logic [IADDR_W-1:0]  int_addr,
  output logic [IDATA_W-1:0]  int_wdata,
  input  logic [IDATA_W-1:0]  int_rdata,
  input  logic                ev_tx,
  input  logic                ev_rx,
  output logic                irq,
  output logic                eng_srst,
  output logic [1:0]          clk_mode,
  output logic                eng_clk_on
);

  logic rs_q1, rs_q2;
  logic rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_ni = rs_q2;

  logic wr_ctrl, wr_cmd, wr_mask, wr_clear;
  assign wr_ctrl  = host_wr & (host_addr == WIN_CTRL);
  assign wr_cmd   = host_wr & (host_addr == WIN_CMD);
  assign wr_mask  = host_wr & (host_addr == WIN_MASK);
  assign wr_clear = host_wr & (host_addr == WIN_CLEAR);

  logic      ctrl_srst;
  clk_mode_e ctrl_mode;

  ireg_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr_en (wr_ctrl),
    .wdata (host_wdata[2:0]),
    .srst  (ctrl_srst),
    .mode  (ctrl_mode)
  );

  icmd_t              cmd_in;
  icmd_t              cmd_q;
  logic               acc_busy;
  logic [IDATA_W-1:0] rd_q;

  always_comb begin
    cmd_in.addr  = host_wdata[IADDR_W-1:0];
    cmd_in.wdata = host_wdata[CMD_WDATA_LSB +: IDATA_W];
    cmd_in.we    = host_wdata[CMD_WE_BIT];
  end

  ireg_access_seq #(.ACCESS_TICKS(ACCESS_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .srst      (ctrl_srst),
    .start_req (wr_cmd),
    .cmd_in    (cmd_in),
    .slow_tick (slow_tick),
    .int_rdata (int_rdata),
    .busy      (acc_busy),
    .cmd_q     (cmd_q),
    .rd_q      (rd_q),
    .int_we    (int_we),
    .int_re    (int_re)
  );

  assign int_addr  = cmd_q.addr;
  assign int_wdata = cmd_q.wdata;

  logic [NUM_IRQ-1:0] mask_q;
  logic [NUM_IRQ-1:0] stat_q;

  ireg_irq_unit #(.NSRC(NUM_IRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_ni),
    .ev      ({ev_rx, ev_tx}),
    .mask_wr (wr_mask),
    .clr_wr  (wr_clear),
    .wsrc    (host_wdata[IRQ_LSB +: NUM_IRQ]),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  logic [31:0] cmd_word;
  always_comb begin
    cmd_word                                  = '0;
    cmd_word[IADDR_W-1:0]                     = cmd_q.addr;
    cmd_word[CMD_WDATA_LSB +: IDATA_W]        = cmd_q.wdata;
    cmd_word[CMD_WE_BIT]                      = cmd_q.we;
    cmd_word[CMD_BUSY_BIT]                    = acc_busy;
    cmd_word[CMD_RDATA_LSB +: IDATA_W]        = rd_q;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      WIN_CTRL:   host_rdata[2:0] = {ctrl_mode, ctrl_srst};
      WIN_CMD:    host_rdata = cmd_word;
      WIN_MASK:   host_rdata[IRQ_LSB +: NUM_IRQ] = mask_q;
      WIN_STATUS: host_rdata[IRQ_LSB +: NUM_IRQ] = stat_q;
      default:    host_rdata = '0;
    endcase
  end

  assign eng_srst   = ctrl_srst;
  assign clk_mode   = ctrl_mode;
  assign eng_clk_on = (ctrl_mode == CLK_GATED) || (ctrl_mode == CLK_FREE);

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata[31:CMD_WE_BIT+1]};

endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srst,
  input logic       busy,
  input logic       slow_tick,
  input logic       int_we,
  input logic       int_re,
  input logic [7:0] int_addr,
  input logic       ev_tx,
  input logic       mask_tx,
  input logic       irq
);

  // R7: soft reset forces the access machine idle on the next cycle
  assert_srst_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !busy);

  // R4: never both strobes at once
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_we, int_re}));

  // R4: a strobe only happens inside an access, on a tick, outside soft reset
  assert_strobe_in_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_we || int_re) |-> (busy && slow_tick && !srst));

  // R4: busy only ends through a strobe or a soft reset
  assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(int_we || int_re || srst));

  // R3: the internal address holds for the whole access
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(int_addr));

  // R10: an enabled transmit event raises the interrupt on the next cycle
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx && mask_tx) |=> irq);

endmodule

bind ireg_bridge ireg_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .srst      (ctrl_srst),
  .busy      (acc_busy),
  .slow_tick (slow_tick),
  .int_we    (int_we),
  .int_re    (int_re),
  .int_addr  (int_addr),
  .ev_tx     (ev_tx),
  .mask_tx   (mask_q[0]),
  .irq       (irq)
);

// File: tb/sim_ireg_bridge.sv
module sim_ireg_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int ACC = 4;

  logic        clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        host_wr;
  logic [2:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        slow_tick;
  logic        int_we, int_re;
  logic [7:0]  int_addr, int_wdata, int_rdata;
  logic        ev_tx, ev_rx;
  logic        irq, eng_srst, eng_clk_on;
  logic [1:0]  clk_mode;

  ireg_bridge #(.ACCESS_TICKS(ACC)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .slow_tick(slow_tick),
    .int_we(int_we), .int_re(int_re), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .ev_tx(ev_tx), .ev_rx(ev_rx), .irq(irq),
    .eng_srst(eng_srst), .clk_mode(clk_mode), .eng_clk_on(eng_clk_on)
  );

  // engine register space seen by the design
  logic [7:0] ext_mem [256];
  assign int_rdata = ext_mem[int_addr];
  always @(posedge clk) if (int_we) ext_mem[int_addr] <= int_wdata;

  // reference model state
  logic [7:0] m_mem [256];
  logic [2:0] m_ctrl;
  logic [1:0] m_mask, m_stat;
  logic       m_busy, m_we, m_rs1, m_rs2;
  int         m_cnt;
  logic [7:0] m_addr, m_wd, m_rd;
  logic       m_fire;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc_n = 0;
  int    tick_div = 3;
  logic  rst_req = 1'b0;
  string cur_req = "R1";
  logic  done = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", cur_req, what, act, exp, cyc_n);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 3'b001; m_mask = '0; m_stat = '0; m_busy = 1'b0; m_we = 1'b0;
    m_cnt = 0; m_addr = '0; m_wd = '0; m_rd = '0;
  endtask

  function automatic logic [31:0] exp_word(input logic [2:0] a);
    case (a)
      3'd0: exp_word = {29'd0, m_ctrl};
      3'd1: exp_word = {m_rd, m_busy, 6'd0, m_we, m_wd, m_addr};
      3'd2: exp_word = {29'd0, m_mask, 1'b0};
      3'd4: exp_word = {29'd0, m_stat, 1'b0};
      default: exp_word = 32'd0;
    endcase
  endfunction

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                     input logic etx, input logic erx);
    logic srst_old;
    @(negedge clk);
    cyc_n++;
    rst_n = rst_req;
    host_wr = wr; host_addr = a; host_wdata = d; ev_tx = etx; ev_rx = erx;
    slow_tick = (tick_div <= 1) ? 1'b1 : ((cyc_n % tick_div) == 0);
    #1;
    m_fire = m_busy && slow_tick && (m_cnt == ACC-1) && !m_ctrl[0];
    chk("host_rdata", host_rdata, exp_word(a));
    chk("irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    chk("eng_srst", {31'd0, eng_srst}, {31'd0, m_ctrl[0]});
    chk("clk_mode", {30'd0, clk_mode}, {30'd0, m_ctrl[2:1]});
    chk("eng_clk_on", {31'd0, eng_clk_on},
        {31'd0, (m_ctrl[2:1] == 2'd1) || (m_ctrl[2:1] == 2'd2)});
    chk("int_we", {31'd0, int_we}, {31'd0, m_fire && m_we});
    chk("int_re", {31'd0, int_re}, {31'd0, m_fire && !m_we});
    if (m_fire) begin
      chk("int_addr", {24'd0, int_addr}, {24'd0, m_addr});
      if (m_we) chk("int_wdata", {24'd0, int_wdata}, {24'd0, m_wd});
    end
    @(posedge clk);
    if (!rst_n) begin
      model_reset();
      m_rs1 = 1'b0; m_rs2 = 1'b0;
    end else begin
      if (m_rs2) begin
        srst_old = m_ctrl[0];
        if (wr && a == 3'd0) m_ctrl = d[2:0];
        if (wr && a == 3'd2) m_mask = d[2:1];
        for (int i = 0; i < 2; i++) begin
          if (wr && a == 3'd3 && d[i+1]) m_stat[i] = 1'b0;
        end
        if (etx) m_stat[0] = 1'b1;
        if (erx) m_stat[1] = 1'b1;
        if (srst_old) begin
          m_busy = 1'b0; m_cnt = 0; m_rd = 8'd0;
        end else if (wr && a == 3'd1 && !m_busy) begin
          m_busy = 1'b1; m_cnt = 0;
          m_addr = d[7:0]; m_wd = d[15:8]; m_we = d[16];
        end else if (m_busy && slow_tick) begin
          if (m_cnt == ACC-1) begin
            m_busy = 1'b0; m_cnt = 0;
            if (m_we) m_mem[m_addr] = m_wd;
            else      m_rd = m_mem[m_addr];
          end else begin
            m_cnt++;
          end
        end
      end
      m_rs2 = m_rs1;
      m_rs1 = 1'b1;
    end
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int k = 0; k < n; k++) cyc(1'b0, a, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    if (!done && cyc_n > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ext_mem[i] = 8'((i * 37 + 11) & 8'hff);
      m_mem[i]   = 8'((i * 37 + 11) & 8'hff);
    end
    model_reset();
    m_rs1 = 1'b0; m_rs2 = 1'b0;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    ev_tx = 1'b0; ev_rx = 1'b0; slow_tick = 1'b0;

    // R1: reset values, and a write during the synchronizer delay is dropped
    cur_req = "R1";
    idle(3, 3'd0);
    rst_req = 1'b1;
    hw(3'd2, 32'h6);
    for (int a = 0; a < 8; a++) idle(1, 3'(a));

    // R2: control word and clock mode decoding
    cur_req = "R2";
    hw(3'd0, 32'h2); idle(1, 3'd0);
    hw(3'd0, 32'h4); idle(1, 3'd0);
    hw(3'd0, 32'h6); idle(1, 3'd0);
    hw(3'd0, 32'hFFFF_FFF8); idle(1, 3'd0);
    hw(3'd0, 32'h2); idle(1, 3'd0);

    // R3 R4: write access with a sparse tick
    cur_req = "R3";
    hw(3'd1, 32'h0001_A510);
    idle(2, 3'd1);
    cur_req = "R4";
    idle(14, 3'd1);
    // R5: read back what was written, then a preset location
    cur_req = "R5";
    hw(3'd1, 32'h0000_0010); idle(16, 3'd1);
    hw(3'd1, 32'h0000_0033); idle(16, 3'd1);
    // R5: a write access keeps the last read byte
    hw(3'd1, 32'h0001_5A77); idle(16, 3'd1);
    // R4: tick on every cycle
    cur_req = "R4";
    tick_div = 1;
    hw(3'd1, 32'h0000_0077); idle(6, 3'd1);
    tick_div = 2;
    hw(3'd1, 32'h0000_00FF); idle(10, 3'd1);

    // R6: commands written during busy are ignored
    cur_req = "R6";
    tick_div = 3;
    hw(3'd1, 32'h0000_0040);
    idle(2, 3'd1);
    hw(3'd1, 32'h0001_EE41);
    idle(2, 3'd1);
    hw(3'd1, 32'h0000_0042);
    idle(12, 3'd1);
    hw(3'd1, 32'h0000_0041); idle(14, 3'd1);

    // R7: soft reset mid-access, commands blocked while held
    cur_req = "R7";
    hw(3'd1, 32'h0000_0050);
    idle(4, 3'd1);
    hw(3'd0, 32'h3);
    idle(14, 3'd1);
    hw(3'd1, 32'h0001_9950);
    idle(14, 3'd1);
    hw(3'd0, 32'h2);
    idle(2, 3'd1);
    hw(3'd1, 32'h0000_0050); idle(14, 3'd1);

    // R8: mask word
    cur_req = "R8";
    hw(3'd2, 32'hFFFF_FFFF); idle(1, 3'd2);
    hw(3'd2, 32'h0000_0000); idle(1, 3'd2);

    // R9 R10: events, clears and interrupt gating
    cur_req = "R9";
    cyc(1'b0, 3'd4, 32'd0, 1'b1, 1'b0); idle(2, 3'd4);
    cur_req = "R10";
    hw(3'd2, 32'h2); idle(2, 3'd4);
    cur_req = "R9";
    hw(3'd3, 32'h0); idle(1, 3'd4);
    hw(3'd3, 32'h2); idle(1, 3'd3);
    cyc(1'b0, 3'd4, 32'd0, 1'b0, 1'b1); idle(1, 3'd4);
    cur_req = "R10";
    hw(3'd2, 32'h4); idle(1, 3'd4);
    cyc(1'b0, 3'd4, 32'd0, 1'b1, 1'b0); idle(1, 3'd4);
    cur_req = "R9";
    cyc(1'b1, 3'd3, 32'h6, 1'b1, 1'b0); idle(2, 3'd4);
    hw(3'd3, 32'h6); idle(1, 3'd4);

    // R11: status word is read-only, indices 5 to 7 are empty
    cur_req = "R11";
    hw(3'd4, 32'h6); idle(1, 3'd4);
    hw(3'd5, 32'hFFFF_FFFF); hw(3'd6, 32'h7); hw(3'd7, 32'h6);
    for (int a = 0; a < 8; a++) idle(1, 3'(a));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule